// File: doc/BRIEF.md
# Bitfield Extract and Insert Unit

A purely combinational datapath element for a small command-processing engine. It takes two 32-bit register operands, A and B, plus three 5-bit fields decoded from the instruction word: a source bit position, a field size and a destination bit position. A 2-bit mode input selects one of three operations. The first copies a field of B into A. The second pulls a field out of B at a bit position held in A and drops it at a fixed position. The third pulls a field out of B at a fixed position and shifts it left by a count held in A. The neighbouring decoder takes the source position from instruction bits 21:17, the size from bits 26:22 and the destination position from bits 31:27. It feeds those fields straight in.

The field mask has one bit set for each unit of size, starting at bit 0. A size of zero therefore gives an empty field, and the widest field is 31 bits. A shift count taken from a register operand is compared at its full width, so a count of 32 or more moves every bit out rather than wrapping. Register file, write-back and result routing sit outside this unit. The unit has no clock and no state.

Top module: `bitfield_unit`

## Requirements
- R1: With a field size of 0 the mask is empty. Mode 0 then returns A unchanged, and modes 1 and 2 return 0.
- R2: Mode 0 (insert) places bits [src+size-1 : src] of B at bits [dst+size-1 : dst] of the result.
- R3: In mode 0, every result bit outside [dst+size-1 : dst] equals the same bit of A.
- R4: Mode 1 (register-positioned extract) places bits [A+size-1 : A] of B at bits [dst+size-1 : dst] of the result, and all other bits are 0.
- R5: Mode 2 (register-shifted extract) places bits [src+size-1 : src] of B at bits [A+size-1 : A] of the result, and all other bits are 0.
- R6: In modes 1 and 2, a value of A of 32 or more gives a result of 0.
- R7: Mode 3 gives a result of 0 whatever the other inputs are.
- R8: Field bits that would land above bit 31 are dropped. Source bits taken from above bit 31 of B read as 0.
- R9: A size of 31 moves a 31-bit field. In mode 0 with dst 0, bit 31 of A is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mode_i | input | 2 | Operation select: 0 insert, 1 extract at register position, 2 extract with register shift, 3 zero |
| opa_i | input | 32 | Register operand A: insert target, or register-supplied shift count |
| opb_i | input | 32 | Register operand B: field source |
| src_pos_i | input | 5 | Field start bit in B (instruction field) |
| fld_size_i | input | 5 | Field width in bits (instruction field) |
| dst_pos_i | input | 5 | Field start bit in the result (instruction field) |
| result_o | output | 32 | Computed result |

## Verification
The unit holds no state, so a fault in its internal shift network or mask shows up at result_o in the same evaluation as the inputs that reach it. Nothing can hide until later. The bench therefore compares every applied vector against a bit-by-bit reference. It aims directed vectors at the points where a wrong shift stage or an unsaturated count would differ: empty and 31-bit fields, fields that run off the top of the word, and register counts of exactly 32 and above. A stuck mode decode shows up as a value from the wrong formula, or a non-zero result in mode 3.

// File: rtl/bfu_pkg.sv
// Shared definitions for the bitfield unit.
// Assumes a data width that is a power of two.
package bfu_pkg;
    localparam int BFU_DATA_W = 32;
    localparam int BFU_POS_W  = $clog2(BFU_DATA_W);

    typedef enum logic [1:0] {
        BFU_INSERT  = 2'd0,
        BFU_EXT_REG = 2'd1,
        BFU_SHL_REG = 2'd2,
        BFU_ZERO    = 2'd3
    } bfu_mode_e;
endpackage

// File: rtl/bfu_shift.sv
// Logarithmic shifter, left or right chosen by the LEFT parameter.
// A count of DATA_W or more clears the output instead of wrapping.
// Assumes DATA_W is a power of two and AMT_W >= log2(DATA_W).
module bfu_shift #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 32,
    parameter bit LEFT   = 1'b1
) (
    input  logic [DATA_W-1:0] din,
    input  logic [AMT_W-1:0]  amt,
    output logic [DATA_W-1:0] dout
);
    localparam int STG = $clog2(DATA_W);

    logic [DATA_W-1:0] stage [STG+1];
    logic              too_far;

    // Stage 0 is the unshifted input.
    assign stage[0] = din;

    // Each stage shifts by a power of two when its count bit is set.
    for (genvar s = 0; s < STG; s++) begin : g_stage
        if (LEFT) begin : g_left
            assign stage[s+1] = amt[s] ?
                {stage[s][DATA_W-1-(2**s):0], {(2**s){1'b0}}} : stage[s];
        end else begin : g_right
            assign stage[s+1] = amt[s] ?
                {{(2**s){1'b0}}, stage[s][DATA_W-1:(2**s)]} : stage[s];
        end
    end

    // Count bits above the stage range mean the whole word is shifted out.
    if (AMT_W > STG) begin : g_sat
        assign too_far = |amt[AMT_W-1:STG];
    end else begin : g_nosat
        assign too_far = 1'b0;
    end

    // Final output with saturation to zero.
    assign dout = too_far ? '0 : stage[STG];
endmodule

// File: rtl/bfu_mask.sv
// Builds a low-aligned mask with one bit set for each unit of size.
// A size of 0 gives an empty mask.
module bfu_mask #(
    parameter int DATA_W = 32,
    parameter int POS_W  = 5
) (
    input  logic [POS_W-1:0]  size,
    output logic [DATA_W-1:0] mask
);
    // Bit i is set when it lies below the field size.
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign mask[i] = (i < int'(size));
    end
endmodule

// File: rtl/bitfield_unit.sv
// Combinational bitfield unit: insert, register-positioned extract and
// register-shifted extract. The datapath is one right shift, a mask AND and a
// left shift. A third shifter places the mask for the insert window.
// Assumes instruction fields are already decoded. There is no state.
module bitfield_unit
    import bfu_pkg::*;
#(
    parameter int DATA_W = BFU_DATA_W,
    parameter int POS_W  = $clog2(DATA_W)
) (
    input  logic [1:0]        mode_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic [POS_W-1:0]  src_pos_i,
    input  logic [POS_W-1:0]  fld_size_i,
    input  logic [POS_W-1:0]  dst_pos_i,
    output logic [DATA_W-1:0] result_o
);
    localparam int PAD_W = DATA_W - POS_W;

    bfu_mode_e         mode;
    logic [DATA_W-1:0] src_ext, dst_ext;
    logic [DATA_W-1:0] rsh_amt, lsh_amt;
    logic [DATA_W-1:0] mask, win;
    logic [DATA_W-1:0] field_raw, field, placed;

    // Decode the mode and widen the instruction positions.
    assign mode    = bfu_mode_e'(mode_i);
    assign src_ext = {{PAD_W{1'b0}}, src_pos_i};
    assign dst_ext = {{PAD_W{1'b0}}, dst_pos_i};

    // Choose where each shift count comes from.
    always_comb begin
        rsh_amt = (mode == BFU_EXT_REG) ? opa_i : src_ext;
        lsh_amt = (mode == BFU_SHL_REG) ? opa_i : dst_ext;
    end

    bfu_mask #(.DATA_W(DATA_W), .POS_W(POS_W)) u_mask (
        .size(fld_size_i),
        .mask(mask)
    );

    bfu_shift #(.DATA_W(DATA_W), .AMT_W(DATA_W), .LEFT(1'b0)) u_rsh (
        .din (opb_i),
        .amt (rsh_amt),
        .dout(field_raw)
    );

    // Isolate the field at bit 0.
    assign field = field_raw & mask;

    bfu_shift #(.DATA_W(DATA_W), .AMT_W(DATA_W), .LEFT(1'b1)) u_lsh (
        .din (field),
        .amt (lsh_amt),
        .dout(placed)
    );

    bfu_shift #(.DATA_W(DATA_W), .AMT_W(POS_W), .LEFT(1'b1)) u_win (
        .din (mask),
        .amt (dst_pos_i),
        .dout(win)
    );

    // Merge per mode.
    always_comb begin
        unique case (mode)
            BFU_INSERT:  result_o = (opa_i & ~win) | placed;
            BFU_EXT_REG: result_o = placed;
            BFU_SHL_REG: result_o = placed;
            default:     result_o = '0;
        endcase
    end
endmodule

// File: rtl/bitfield_unit_chk.sv
// Port-level checker for bitfield_unit, bound to every instance.
// Holds immediate assertions only, since the unit has no clock.
module bitfield_unit_chk #(
    parameter int DATA_W = 32,
    parameter int POS_W  = 5
) (
    input logic [1:0]        mode_i,
    input logic [DATA_W-1:0] opa_i,
    input logic [DATA_W-1:0] opb_i,
    input logic [POS_W-1:0]  src_pos_i,
    input logic [POS_W-1:0]  fld_size_i,
    input logic [POS_W-1:0]  dst_pos_i,
    input logic [DATA_W-1:0] result_o
);
    // Window of bits [lo+size-1 : lo], computed from the ports only.
    function automatic logic [DATA_W-1:0] window(longint lo, longint size);
        logic [DATA_W-1:0] w;
        w = '0;
        for (int i = 0; i < DATA_W; i++) begin
            w[i] = (i >= lo) && (i < lo + size);
        end
        return w;
    endfunction

    // Check each mode's invariants whenever the inputs or result change.
    always_comb begin
        logic [DATA_W-1:0] wd, wa;
        logic              big;
        wd  = window(longint'(dst_pos_i), longint'(fld_size_i));
        wa  = window(longint'(opa_i), longint'(fld_size_i));
        big = (longint'(opa_i) >= longint'(DATA_W));

        p_zero_mode_r7: assert (mode_i != 2'd3 || result_o == '0)
            else $error("mode 3 result not zero");
        p_insert_keeps_a_r3: assert (mode_i != 2'd0 || ((result_o ^ opa_i) & ~wd) == '0)
            else $error("insert altered bits outside the field");
        p_empty_insert_r1: assert (!(mode_i == 2'd0 && fld_size_i == '0) || result_o == opa_i)
            else $error("empty insert changed A");
        p_empty_extract_r1: assert (!((mode_i == 2'd1 || mode_i == 2'd2) && fld_size_i == '0)
                                    || result_o == '0)
            else $error("empty extract not zero");
        p_reg_big_zero_r6: assert (!((mode_i == 2'd1 || mode_i == 2'd2) && big) || result_o == '0)
            else $error("large register count did not clear");
        p_extract_clean_r4: assert (mode_i != 2'd1 || (result_o & ~wd) == '0)
            else $error("extract leaked outside destination window");
        p_shift_clean_r5: assert (mode_i != 2'd2 || (result_o & ~wa) == '0)
            else $error("shifted extract leaked outside window");
    end
endmodule

bind bitfield_unit bitfield_unit_chk #(.DATA_W(DATA_W), .POS_W(POS_W)) u_chk (
    .mode_i    (mode_i),
    .opa_i     (opa_i),
    .opb_i     (opb_i),
    .src_pos_i (src_pos_i),
    .fld_size_i(fld_size_i),
    .dst_pos_i (dst_pos_i),
    .result_o  (result_o)
);

// File: tb/bitfield_unit_bench.sv
// Bench for bitfield_unit: directed corner vectors, then pseudo-random
// vectors compared against a bit-by-bit behavioural model, one per clock.
module bitfield_unit_bench;
    logic        clk = 1'b0;
    logic [1:0]  mode;
    logic [31:0] opa, opb;
    logic [4:0]  srcp, fsz, dstp;
    logic [31:0] res;
    int          n_run  = 0;
    int          n_fail = 0;
    bit          done   = 1'b0;
    logic [31:0] seed   = 32'h1234_5678;

    always #5 clk = ~clk;

    bitfield_unit u_bitfield_unit (
        .mode_i    (mode),
        .opa_i     (opa),
        .opb_i     (opb),
        .src_pos_i (srcp),
        .fld_size_i(fsz),
        .dst_pos_i (dstp),
        .result_o  (res)
    );

    // Behavioural model: walks each result bit and finds its source bit.
    function automatic logic [31:0] model(int m, logic [31:0] a, logic [31:0] b,
                                          int src, int size, int dst);
        logic [31:0] r;
        longint av, j;
        av = a;
        r  = (m == 0) ? a : 32'd0;
        for (int i = 0; i < 32; i++) begin
            j = -1;
            if (m == 0 && i >= dst && i < dst + size) j = i - dst + src;
            if (m == 1 && i >= dst && i < dst + size) j = i - dst + av;
            if (m == 2 && i >= av && i < av + size)   j = i - av + src;
            if (m <= 2 && j >= 0) r[i] = (j < 32) ? b[int'(j)] : 1'b0;
            else if (m <= 2 && m != 0) r[i] = 1'b0;
        end
        return (m == 3) ? 32'd0 : r;
    endfunction

    // Applies one vector and checks the result in mid-cycle.
    task automatic apply(input int m, input logic [31:0] a, input logic [31:0] b,
                         input int s, input int z, input int d,
                         input logic [31:0] exp, input string tag);
        @(posedge clk);
        #1;
        mode = 2'(m); opa = a; opb = b;
        srcp = 5'(s); fsz = 5'(z); dstp = 5'(d);
        #3;
        n_run++;
        if (res !== exp) begin
            n_fail++;
            $display("FAIL %s: mode=%0d a=%h b=%h src=%0d size=%0d dst=%0d got %h expected %h",
                     tag, m, a, b, s, z, d, res, exp);
        end
    endtask

    function automatic logic [31:0] nxt(logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    // Ends a hung run as a failure.
    initial begin
        for (int c = 0; c < 200000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        mode = '0; opa = '0; opb = '0; srcp = '0; fsz = '0; dstp = '0;
        // R2: basic insert
        apply(0, 32'hFFFF_FFFF, 32'h0000_00AB, 0, 8, 8, 32'hFFFF_ABFF, "R2");
        apply(0, 32'h0000_0000, 32'hF0F0_F0F0, 4, 4, 28, 32'hF000_0000, "R2");
        // R1: empty field
        apply(0, 32'h1234_5678, 32'hFFFF_FFFF, 3, 0, 9, 32'h1234_5678, "R1");
        apply(1, 32'h0000_0004, 32'hFFFF_FFFF, 0, 0, 2, 32'h0000_0000, "R1");
        apply(2, 32'h0000_0004, 32'hFFFF_FFFF, 0, 0, 2, 32'h0000_0000, "R1");
        // R3: bits of A outside the field survive
        apply(0, 32'hA5A5_A5A5, 32'h0000_0000, 0, 4, 12, 32'hA5A5_05A5, "R3");
        // R4: extract at register position
        apply(1, 32'h0000_0008, 32'h0000_AB00, 0, 8, 4, 32'h0000_0AB0, "R4");
        // R5: extract with register shift
        apply(2, 32'h0000_0004, 32'h0000_0F00, 8, 4, 0, 32'h0000_00F0, "R5");
        // R6: large register counts
        apply(1, 32'h0000_0020, 32'hFFFF_FFFF, 0, 8, 0, 32'h0000_0000, "R6");
        apply(1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 8, 0, 32'h0000_0000, "R6");
        apply(2, 32'h0000_0028, 32'hFFFF_FFFF, 0, 8, 0, 32'h0000_0000, "R6");
        apply(2, 32'h0000_0020, 32'hFFFF_FFFF, 0, 8, 0, 32'h0000_0000, "R6");
        // R7: mode 3
        apply(3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 9, 3, 32'h0000_0000, "R7");
        // R8: fields past the top of the word
        apply(0, 32'h0000_0000, 32'h0000_00FF, 0, 8, 30, 32'hC000_0000, "R8");
        apply(1, 32'h0000_001C, 32'hFFFF_FFFF, 0, 8, 0, 32'h0000_000F, "R8");
        apply(2, 32'h0000_001F, 32'h0000_0003, 0, 2, 0, 32'h8000_0000, "R8");
        // R9: widest field
        apply(2, 32'h0000_0001, 32'hFFFF_FFFF, 0, 31, 0, 32'hFFFF_FFFE, "R9");
        apply(0, 32'h8000_0000, 32'h0000_0000, 0, 31, 0, 32'h8000_0000, "R9");
        apply(0, 32'h0000_0000, 32'hFFFF_FFFF, 0, 31, 0, 32'h7FFF_FFFF, "R9");
        // Pseudo-random vectors against the model.
        for (int k = 0; k < 400; k++) begin
            logic [31:0] a, b, r;
            int m, s, z, d;
            seed = nxt(seed); a = seed;
            seed = nxt(seed); b = seed;
            seed = nxt(seed);
            m = int'(seed[1:0]); s = int'(seed[6:2]); z = int'(seed[11:7]);
            d = int'(seed[16:12]);
            if (m != 0 && seed[17]) a = {27'd0, seed[22:18]} + 32'(seed[23]);
            r = model(m, a, b, s, z, d);
            case (m)
                0:       apply(m, a, b, s, z, d, r, "R2/R3 random insert");
                1:       apply(m, a, b, s, z, d, r, "R4 random extract");
                2:       apply(m, a, b, s, z, d, r, "R5 random shifted extract");
                default: apply(m, a, b, s, z, d, r, "R7 random zero mode");
            endcase
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule